// File: doc/BRIEF.md
# Multiplexed Converter Host Sequencer

This block is the host-side controller for an external eight-input multiplexed analog-to-digital converter. It runs on the system clock and drives the converter's pins in the right order. It first places a channel number on the address lines and strobes the address latch. It then pulses the start line and waits for the converter's end-of-conversion line to go low and then high again. Finally it raises output enable, waits for the converter's data bus to settle, and captures the 8-bit result. Every interface delay is a parameter in system clock cycles, worked out from nanosecond timing limits and the system clock rate. The defaults assume a 100 MHz clock.

A user either hands the block one channel at a time through a valid/ready request port, or sets the scan input. In scan mode the block converts channels 0 to 7 in turn and then wraps to 0. Each result comes back with a one-cycle valid strobe and its channel number. End-of-conversion reaches the block through a two-flop synchroniser. If the falling-then-rising handshake does not complete within a timeout, the block pulses an error flag and returns to idle. The block can also generate the converter's clock by dividing the system clock.

The controller's states are:
- IDLE: accepts work.
- SETUP: the address is settling before the latch strobe.
- LATCH: the latch strobe is high.
- HOLD: the address is held after the strobe.
- START: the start pulse is high.
- WFALL: waiting for end-of-conversion to go low.
- WRISE: waiting for it to go high again.
- OEWAIT: output enable is high while the bus settles.
- CAPTURE: the result is presented.
- FLOAT: the bus is allowed to release.

The transitions are:
- IDLE to SETUP on a request or while scanning.
- SETUP to LATCH, LATCH to HOLD, HOLD to START, START to WFALL, OEWAIT to CAPTURE and FLOAT to IDLE, each when its dwell counter expires.
- WFALL to WRISE when the synchronised end-of-conversion is low.
- WRISE to OEWAIT when it is high.
- WFALL or WRISE to IDLE on timeout.
- CAPTURE to FLOAT unconditionally.

Top module: `conv_seq_top`

## Requirements
- R1: While reset is asserted, the outputs are in their idle state: latch strobe, start, output enable, result valid and error are all 0, and request ready is 1 when scan is off.
- R2: The converter address equals the accepted channel. It is stable for at least SETUP_CYC cycles before the latch strobe rises, and it stays unchanged until the start pulse rises.
- R3: The latch strobe is high for exactly ALE_CYC cycles. Start rises exactly HOLD_CYC cycles after the strobe falls and stays high for exactly START_CYC cycles.
- R4: A result is produced only after the synchronised end-of-conversion has gone low and then high again after start. A line that is still high after start never counts as completion.
- R5: Output enable stays high for exactly OE_CYC cycles. The result-valid strobe is high for one cycle, in the cycle right after output enable falls. It carries the bus value present at the last enabled cycle and the channel of that conversion.
- R6: After output enable falls, at least FLOAT_CYC + SETUP_CYC + 2 cycles pass before the next latch strobe rises.
- R7: If the handshake has not completed within TIMEOUT_CYC cycles after start falls, the error flag pulses for one cycle instead of a result, and the block returns to idle.
- R8: While scan is set, request ready is 0 and requests are ignored. Conversions run on channels 0, 1, …, 7, 0, … and each result reports its channel.
- R9: When CLK_HALF is nonzero, the converter clock has a period of exactly 2·CLK_HALF system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Single-conversion request |
| req_chan | input | CH_W | Channel for the request |
| req_ready | output | 1 | Request accepted on this cycle when high with req_valid |
| scan_en | input | 1 | Scan all channels in turn |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_chan | output | CH_W | Channel of the result or of the failed conversion |
| rsp_data | output | DATA_W | Captured result |
| err_timeout | output | 1 | One-cycle pulse on handshake timeout |
| conv_clk | output | 1 | Generated converter clock |
| conv_addr | output | CH_W | Multiplexer address to the converter |
| conv_ale | output | 1 | Address latch strobe |
| conv_start | output | 1 | Start-of-conversion pulse |
| conv_eoc | input | 1 | Asynchronous end-of-conversion from the converter |
| conv_oe | output | 1 | Output enable to the converter |
| conv_data | input | DATA_W | Converter data bus |

## Verification
Single requests go to random channels. For each one the converter model picks a random delay before end-of-conversion falls, including zero, where the line falls during the start pulse, and a random time for it to stay low. This separates a controller that truly waits for both transitions from one that takes the idle-high level as completion. The model drives a marker value on the bus until output enable has been high for three cycles, so a capture that comes too early returns the marker instead of the expected result. Two directed cases cover timeouts: one where the line never falls and one where it never rises. A scan run of ten conversions, with a conflicting request held active, checks the channel order, the wrap and that requests are ignored during the scan.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SETUP,
        S_LATCH,
        S_HOLD,
        S_START,
        S_WFALL,
        S_WRISE,
        S_OEWAIT,
        S_CAPTURE,
        S_FLOAT
    } seq_state_t;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/conv_clk_div.sv
module conv_clk_div #(
    parameter int unsigned HALF = 78
) (
    input  logic clk,
    input  logic rst_n,
    output logic clk_o
);
    generate
        if (HALF == 0) begin : g_off
            assign clk_o = 1'b0;
        end else begin : g_div
            localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
            logic [CW-1:0] cnt;
            logic          ck;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt <= CW'(HALF - 1);
                    ck  <= 1'b0;
                end else if (cnt == '0) begin
                    cnt <= CW'(HALF - 1);
                    ck  <= ~ck;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end

            assign clk_o = ck;

            // R9: the output only toggles when the divider count expires
            assert_div_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (cnt != '0) |=> $stable(ck));
        end
    endgenerate
endmodule

// File: rtl/conv_eoc_sync.sv
module conv_eoc_sync #(
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RESET_VAL;
            sync_q <= RESET_VAL;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
        end
    end

    assign sync_out = sync_q;
endmodule

// File: rtl/conv_seq_fsm.sv
module conv_seq_fsm
    import conv_seq_pkg::*;
#(
    parameter int unsigned CH_W        = 3,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SETUP_CYC   = 5,
    parameter int unsigned HOLD_CYC    = 5,
    parameter int unsigned ALE_CYC     = 20,
    parameter int unsigned START_CYC   = 20,
    parameter int unsigned OE_CYC      = 25,
    parameter int unsigned FLOAT_CYC   = 25,
    parameter int unsigned TIMEOUT_CYC = 20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CH_W-1:0]   req_chan,
    input  logic              scan_en,
    input  logic              eoc_s,
    input  logic [DATA_W-1:0] bus_data,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [CH_W-1:0]   rsp_chan,
    output logic [DATA_W-1:0] rsp_data,
    output logic              err_timeout,
    output logic [CH_W-1:0]   conv_addr,
    output logic              conv_ale,
    output logic              conv_start,
    output logic              conv_oe
);
    localparam int unsigned DMAX   = max2(max2(max2(SETUP_CYC, HOLD_CYC), max2(ALE_CYC, START_CYC)),
                                          max2(OE_CYC, FLOAT_CYC));
    localparam int unsigned DCNT_W = $clog2(DMAX + 1);
    localparam int unsigned TCNT_W = $clog2(TIMEOUT_CYC + 1);

    seq_state_t        state, next;
    logic [DCNT_W-1:0] dcnt;
    logic [TCNT_W-1:0] tcnt;
    logic [CH_W-1:0]   chan_q;
    logic [CH_W-1:0]   scan_idx;
    logic [DATA_W-1:0] data_q;
    logic              err_q;
    logic              timeout;

    function automatic logic [DCNT_W-1:0] dwell(seq_state_t s);
        unique case (s)
            S_SETUP:  return DCNT_W'(SETUP_CYC - 1);
            S_LATCH:  return DCNT_W'(ALE_CYC - 1);
            S_HOLD:   return DCNT_W'(HOLD_CYC - 1);
            S_START:  return DCNT_W'(START_CYC - 1);
            S_OEWAIT: return DCNT_W'(OE_CYC - 1);
            S_FLOAT:  return DCNT_W'(FLOAT_CYC - 1);
            default:  return '0;
        endcase
    endfunction

    // next-state decision
    always_comb begin
        next    = state;
        timeout = 1'b0;
        unique case (state)
            S_IDLE:    if (scan_en || req_valid) next = S_SETUP;
            S_SETUP:   if (dcnt == '0) next = S_LATCH;
            S_LATCH:   if (dcnt == '0) next = S_HOLD;
            S_HOLD:    if (dcnt == '0) next = S_START;
            S_START:   if (dcnt == '0) next = S_WFALL;
            S_WFALL: begin
                if (!eoc_s) begin
                    next = S_WRISE;
                end else if (tcnt == '0) begin
                    next    = S_IDLE;
                    timeout = 1'b1;
                end
            end
            S_WRISE: begin
                if (eoc_s) begin
                    next = S_OEWAIT;
                end else if (tcnt == '0) begin
                    next    = S_IDLE;
                    timeout = 1'b1;
                end
            end
            S_OEWAIT:  if (dcnt == '0) next = S_CAPTURE;
            S_CAPTURE: next = S_FLOAT;
            S_FLOAT:   if (dcnt == '0) next = S_IDLE;
            default:   next = S_IDLE;
        endcase
    end

    // state register, dwell and timeout counters, datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            dcnt     <= '0;
            tcnt     <= '0;
            chan_q   <= '0;
            scan_idx <= '0;
            data_q   <= '0;
            err_q    <= 1'b0;
        end else begin
            state <= next;
            err_q <= timeout;

            if (next != state) begin
                dcnt <= dwell(next);
            end else if (dcnt != '0) begin
                dcnt <= dcnt - 1'b1;
            end

            if (state == S_START) begin
                tcnt <= TCNT_W'(TIMEOUT_CYC - 1);
            end else if ((state == S_WFALL || state == S_WRISE) && tcnt != '0) begin
                tcnt <= tcnt - 1'b1;
            end

            if (state == S_IDLE) begin
                if (scan_en) begin
                    chan_q   <= scan_idx;
                    scan_idx <= scan_idx + 1'b1;
                end else if (req_valid) begin
                    chan_q <= req_chan;
                end
            end

            if (state == S_OEWAIT && next == S_CAPTURE) begin
                data_q <= bus_data;
            end
        end
    end

    // output decode
    always_comb begin
        req_ready   = (state == S_IDLE) && !scan_en;
        conv_ale    = (state == S_LATCH);
        conv_start  = (state == S_START);
        conv_oe     = (state == S_OEWAIT);
        rsp_valid   = (state == S_CAPTURE);
        rsp_chan    = chan_q;
        rsp_data    = data_q;
        err_timeout = err_q;
        conv_addr   = chan_q;
    end

    // R2: once work is accepted, the address does not move until idle
    assert_addr_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |=> $stable(conv_addr));

    // R4: output enable only follows a seen-high line after the wait for rise
    assert_rise_before_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WRISE && next == S_OEWAIT) |-> eoc_s);

    // R5: a result is presented only straight after an enabled cycle
    assert_capture_after_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(conv_oe));

    // R7: a conversion ends in a result or an error, never both
    assert_rsp_err_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && err_timeout));

    // R8: scanning blocks the request port
    assert_scan_blocks_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |-> !req_ready);

    // R3: strobe and start never overlap
    assert_ale_start_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_ale) |-> !conv_start);
endmodule

// File: rtl/conv_seq_top.sv
module conv_seq_top #(
    parameter int unsigned CH_W        = 3,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SETUP_CYC   = 5,
    parameter int unsigned HOLD_CYC    = 5,
    parameter int unsigned ALE_CYC     = 20,
    parameter int unsigned START_CYC   = 20,
    parameter int unsigned OE_CYC      = 25,
    parameter int unsigned FLOAT_CYC   = 25,
    parameter int unsigned TIMEOUT_CYC = 20000,
    parameter int unsigned CLK_HALF    = 78
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CH_W-1:0]   req_chan,
    output logic              req_ready,
    input  logic              scan_en,
    output logic              rsp_valid,
    output logic [CH_W-1:0]   rsp_chan,
    output logic [DATA_W-1:0] rsp_data,
    output logic              err_timeout,
    output logic              conv_clk,
    output logic [CH_W-1:0]   conv_addr,
    output logic              conv_ale,
    output logic              conv_start,
    input  logic              conv_eoc,
    output logic              conv_oe,
    input  logic [DATA_W-1:0] conv_data
);
    logic eoc_s;

    conv_clk_div #(.HALF(CLK_HALF)) u_clk_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clk_o (conv_clk)
    );

    conv_eoc_sync #(.RESET_VAL(1'b1)) u_eoc_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (conv_eoc),
        .sync_out (eoc_s)
    );

    conv_seq_fsm #(
        .CH_W        (CH_W),
        .DATA_W      (DATA_W),
        .SETUP_CYC   (SETUP_CYC),
        .HOLD_CYC    (HOLD_CYC),
        .ALE_CYC     (ALE_CYC),
        .START_CYC   (START_CYC),
        .OE_CYC      (OE_CYC),
        .FLOAT_CYC   (FLOAT_CYC),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_chan    (req_chan),
        .scan_en     (scan_en),
        .eoc_s       (eoc_s),
        .bus_data    (conv_data),
        .req_ready   (req_ready),
        .rsp_valid   (rsp_valid),
        .rsp_chan    (rsp_chan),
        .rsp_data    (rsp_data),
        .err_timeout (err_timeout),
        .conv_addr   (conv_addr),
        .conv_ale    (conv_ale),
        .conv_start  (conv_start),
        .conv_oe     (conv_oe)
    );
endmodule

// File: tb/conv_seq_top_bench.sv
module conv_seq_top_bench;
    localparam int SETUP = 3;
    localparam int HOLD  = 2;
    localparam int ALE   = 6;
    localparam int START = 5;
    localparam int OE    = 4;
    localparam int FLT   = 3;
    localparam int TOUT  = 300;
    localparam int HALF  = 4;
    localparam int OE_DLY = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_chan = '0;
    logic       req_ready;
    logic       scan_en = 1'b0;
    logic       rsp_valid;
    logic [2:0] rsp_chan;
    logic [7:0] rsp_data;
    logic       err_timeout;
    logic       conv_clk;
    logic [2:0] conv_addr;
    logic       conv_ale;
    logic       conv_start;
    logic       conv_eoc;
    logic       conv_oe;
    logic [7:0] conv_data;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    conv_seq_top #(
        .SETUP_CYC(SETUP), .HOLD_CYC(HOLD), .ALE_CYC(ALE), .START_CYC(START),
        .OE_CYC(OE), .FLOAT_CYC(FLT), .TIMEOUT_CYC(TOUT), .CLK_HALF(HALF)
    ) u_conv_seq_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
        .req_ready(req_ready), .scan_en(scan_en), .rsp_valid(rsp_valid),
        .rsp_chan(rsp_chan), .rsp_data(rsp_data), .err_timeout(err_timeout),
        .conv_clk(conv_clk), .conv_addr(conv_addr), .conv_ale(conv_ale),
        .conv_start(conv_start), .conv_eoc(conv_eoc), .conv_oe(conv_oe),
        .conv_data(conv_data)
    );

    function automatic logic [7:0] conv_value(int ch, int seq);
        return 8'((ch * 37 + seq * 11 + 5)) ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // ---------------- converter model ----------------
    int  m_fall_dly = 2;
    int  m_conv_len = 20;
    bit  m_nofall = 0;
    bit  m_norise = 0;
    bit  m_force_idle = 0;
    int  m_st;
    int  m_cnt;
    int  m_seq;
    int  m_oecnt;
    bit  m_rose;
    logic [2:0] m_addr;
    logic [7:0] m_val;
    logic m_start_q;

    always @(posedge clk) begin
        if (!rst_n || m_force_idle) begin
            m_st <= 0; m_cnt <= 0; conv_eoc <= 1'b1; m_start_q <= 1'b0;
            m_oecnt <= 0; conv_data <= 8'hEE;
            if (!rst_n) begin m_seq <= 0; m_rose <= 0; m_addr <= '0; m_val <= '0; end
        end else begin
            m_start_q <= conv_start;
            if (conv_ale) m_addr <= conv_addr;
            if (conv_start && !m_start_q) begin
                m_st <= 1; m_cnt <= m_fall_dly; m_rose <= 0;
                m_val <= conv_value(int'(m_addr), m_seq);
                m_seq <= m_seq + 1;
            end else if (m_st == 1) begin
                if (m_cnt == 0) begin
                    if (!m_nofall) begin conv_eoc <= 1'b0; m_st <= 2; m_cnt <= m_conv_len; end
                end else m_cnt <= m_cnt - 1;
            end else if (m_st == 2) begin
                if (m_cnt == 0) begin
                    if (!m_norise) begin conv_eoc <= 1'b1; m_rose <= 1; m_st <= 0; end
                end else m_cnt <= m_cnt - 1;
            end
            if (conv_oe) begin
                m_oecnt <= m_oecnt + 1;
                conv_data <= (m_oecnt + 1 >= OE_DLY) ? m_val : 8'hEE;
            end else begin
                m_oecnt <= 0;
                conv_data <= 8'hEE;
            end
        end
    end

    // ---------------- interface timing monitor ----------------
    logic p_ale = 0, p_start = 0, p_oe = 0, p_cclk = 0;
    logic [2:0] p_addr = '0, ale_addr = '0;
    int stable_n = 0, ale_n = 0, start_n = 0, oe_n = 0, hold_n = 0, gap_n = 0;
    int since_start = 0, cp = 0, clk_checks = 0;
    bit hold_act = 0, gap_act = 0, cclk_seen = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            stable_n = (conv_addr == p_addr) ? stable_n + 1 : 0;
            if (conv_ale && !p_ale) begin
                chk(stable_n >= SETUP, "R2 setup", stable_n, SETUP);
                if (gap_act) chk(gap_n >= 2 + FLT + SETUP, "R6 float gap", gap_n, 2 + FLT + SETUP);
                gap_act = 0;
                ale_addr = conv_addr;
                ale_n = 0;
            end
            if (conv_ale) ale_n++;
            if (!conv_ale && p_ale) begin
                chk(ale_n == ALE, "R3 latch width", ale_n, ALE);
                hold_act = 1; hold_n = 0;
            end
            if (conv_start && !p_start) begin
                chk(hold_n == HOLD, "R3 hold gap", hold_n, HOLD);
                chk(conv_addr == ale_addr, "R2 addr held", conv_addr, ale_addr);
                hold_act = 0; start_n = 0;
            end
            if (hold_act) hold_n++;
            if (conv_start) start_n++;
            if (!conv_start && p_start) begin
                chk(start_n == START, "R3 start width", start_n, START);
                since_start = 0;
            end
            since_start++;
            if (err_timeout)
                chk(since_start >= TOUT && since_start <= TOUT + 2, "R7 timeout window", since_start, TOUT + 1);
            if (conv_oe && !p_oe) oe_n = 0;
            if (conv_oe) oe_n++;
            if (!conv_oe && p_oe) begin
                chk(oe_n == OE, "R5 enable width", oe_n, OE);
                chk(rsp_valid == 1'b1, "R5 strobe after enable", rsp_valid, 1);
                gap_act = 1; gap_n = 0;
            end
            if (gap_act) gap_n++;
            cp++;
            if (conv_clk && !p_cclk) begin
                if (cclk_seen && clk_checks < 4) begin
                    chk(cp == 2 * HALF, "R9 clock period", cp, 2 * HALF);
                    clk_checks++;
                end
                cclk_seen = 1; cp = 0;
            end
            p_ale = conv_ale; p_start = conv_start; p_oe = conv_oe;
            p_addr = conv_addr; p_cclk = conv_clk;
        end
    end

    // ---------------- stimulus ----------------
    int b_seq = 0;

    task automatic issue(input int ch);
        @(negedge clk);
        req_valid = 1'b1; req_chan = 3'(ch);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_result(output bit got_rsp, output bit got_err);
        got_rsp = 0; got_err = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (rsp_valid) begin got_rsp = 1; break; end
            if (err_timeout) begin got_err = 1; break; end
        end
    endtask

    task automatic one_conv(input int ch, input int fdly, input int clen);
        bit r, e;
        m_fall_dly = fdly; m_conv_len = clen;
        issue(ch);
        wait_result(r, e);
        chk(r && !e, "R4 result arrives", r, 1);
        if (r) begin
            chk(m_rose, "R4 completion after fall and rise", m_rose, 1);
            chk(rsp_chan == 3'(ch), "R5 result channel", rsp_chan, ch);
            chk(rsp_data == conv_value(ch, b_seq), "R5 result data", rsp_data, conv_value(ch, b_seq));
        end
        b_seq++;
    endtask

    initial begin
        bit r, e;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!conv_ale && !conv_start && !conv_oe, "R1 idle pins", {conv_ale, conv_start, conv_oe}, 0);
        chk(!rsp_valid && !err_timeout, "R1 no result", {rsp_valid, err_timeout}, 0);
        chk(req_ready, "R1 ready", req_ready, 1);
        @(negedge clk); rst_n = 1'b1;

        // directed: line falls during start, long wait before fall
        one_conv(3, 0, 15);
        one_conv(6, 40, 10);
        // constrained random single conversions
        for (int k = 0; k < 14; k++)
            one_conv(int'($urandom_range(0, 7)), int'($urandom_range(0, 10)), int'($urandom_range(10, 60)));

        // R7 line never falls
        m_nofall = 1;
        issue(2);
        wait_result(r, e);
        chk(e && !r, "R7 error on stuck high", e, 1);
        chk(rsp_chan == 3'd2, "R7 error channel", rsp_chan, 2);
        b_seq++;
        m_nofall = 0;
        repeat (3) @(negedge clk);
        chk(req_ready, "R7 back to idle", req_ready, 1);

        // R7 line never rises
        m_norise = 1; m_fall_dly = 1; m_conv_len = 5;
        issue(5);
        wait_result(r, e);
        chk(e && !r, "R7 error on stuck low", e, 1);
        b_seq++;
        m_norise = 0;
        @(negedge clk); m_force_idle = 1;
        @(negedge clk); m_force_idle = 0;
        repeat (4) @(negedge clk);
        one_conv(1, 2, 12);

        // R8 scan with a conflicting request held
        repeat (FLT + 2) @(negedge clk);
        m_fall_dly = 1; m_conv_len = 8;
        req_valid = 1'b1; req_chan = 3'd5;
        scan_en = 1'b1;
        @(negedge clk);
        chk(!req_ready, "R8 ready low in scan", req_ready, 0);
        for (int k = 0; k < 10; k++) begin
            wait_result(r, e);
            chk(r, "R8 scan result", r, 1);
            chk(rsp_chan == 3'(k % 8), "R8 scan channel", rsp_chan, k % 8);
            chk(rsp_data == conv_value(k % 8, b_seq), "R8 scan data", rsp_data, conv_value(k % 8, b_seq));
            b_seq++;
            if (k == 9) begin scan_en = 1'b0; req_valid = 1'b0; end
        end
        repeat (20) @(negedge clk);
        chk(!conv_ale && req_ready, "R8 scan stops", req_ready, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule